// File: doc/BRIEF.md
# Linked-List Descriptor DMA Channel

This block is one DMA channel that runs a chain of copy commands kept in memory. Each command is an eight-word image of the channel's working registers. Software stores the address of the first node in the channel and sets the list-enable bit. The engine then reads the node one word at a time through a simple valid/ready word port, takes the fields into its working registers, and copies data one 32-bit word per beat. Each beat is one read followed by one write. Each side can advance its address after every beat or stay on the same address.

When a command finishes, the engine reads the next-node pointer from that command. A zero pointer stops the channel and clears its enable bits. A non-zero pointer makes it fetch that node. A ring of nodes therefore runs until software cancels it.

A one-cycle event pulse goes to an external counter block. It fires once when the first node of a started list has been fully fetched, and once more each time a command completes. Software can read back the working registers and the remaining size of the current command.

Top module: `lldma_channel`

## Requirements
- R1: A register write to offset 0x1C with bit 4 set and bit 20 clear, while the channel is idle, starts the list. The channel then reads eight words at the node address, +0, +4 … +28, in that order. While the list runs, offset 0x1C reads back bit 0 = 1 and bit 4 = 1.
- R2: Descriptor word 0 is the general config. Bit 8 enables read-address increment and bit 12 enables write-address increment. Word 2 is the source address, word 3 the destination address, word 4 bits [23:0] the byte count minus one, and word 5 the next-node address. Offset 0x08 reads the current source address.
- R3: Each beat reads one word at the source address and writes it to the destination address. After the beat, an address whose increment bit is set advances by 4; otherwise it stays fixed.
- R4: A command moves (count+1)/4 words. Offset 0x30 holds the remaining count minus one, lowered by 4 per beat. It reads 0xFFFFFF when no bytes remain, including after reset.
- R5: The event output pulses for one cycle when the first node of a started list is loaded, and for one cycle after each completed command.
- R6: After a command, a non-zero next-node address makes the channel fetch that node, and offset 0x14 then reads that address. A zero address returns the channel to idle with offset 0x1C reading 0.
- R7: A ring of nodes whose last pointer leads back to the first keeps running and keeps raising events until it is cancelled.
- R8: A write to 0x1C with bit 20 set stops the channel at once. From the next cycle there is no memory request, no further event, and offset 0x1C reads 0.
- R9: A memory request keeps its request, direction, address and write data unchanged until ready is seen.
- R10: Writes to the node register (offset 0x14) while the channel is busy are ignored.
- R11: After reset the channel is idle, makes no memory request and raises no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | REG_AW | Register byte offset within the channel bank |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for regAddr (combinational) |
| memReq | output | 1 | Memory request valid |
| memWe | output | 1 | Request is a write (1) or a read (0) |
| memAddr | output | 32 | Memory byte address (word aligned) |
| memWdata | output | 32 | Memory write data |
| memReady | input | 1 | Memory accepts the request this cycle; read data valid in the same cycle |
| memRdata | input | 32 | Memory read data |
| eventPulse | output | 1 | One-cycle completion event |

## Verification
The hardest state to reach from the ports is a cancel that lands while a ring of nodes is still running, part-way through a fetch or a data beat. The stimulus builds a two-node ring in the bench memory and lets it circulate for hundreds of cycles. It then writes the cancel bit and checks that requests and events stop dead. Table-driven runs cover the increment combinations. Some of these runs stall the memory port every fourth cycle, so that requests are held across wait states. Directed runs cover chaining, node-register writes while busy, and the reset state.

// File: rtl/lldma_pkg.sv
package lldma_pkg;
  localparam int WORD_W     = 32;
  localparam int SIZE_W     = 24;
  localparam int DESC_WORDS = 8;
  localparam int IDX_W      = $clog2(DESC_WORDS);
  localparam int BEAT_BYTES = WORD_W / 8;

  // register offsets inside one channel bank
  localparam int OFS_GEN    = 'h00;
  localparam int OFS_PORT   = 'h04;
  localparam int OFS_SRC    = 'h08;
  localparam int OFS_DST    = 'h0C;
  localparam int OFS_SIZE   = 'h10;
  localparam int OFS_NODE   = 'h14;
  localparam int OFS_CTRL   = 'h1C;
  localparam int OFS_ACTIVE = 'h30;

  // bit positions with fixed meaning
  localparam int BIT_EN      = 0;
  localparam int BIT_LIST    = 4;
  localparam int BIT_CANCEL  = 20;
  localparam int BIT_INC_RD  = 8;
  localparam int BIT_INC_WR  = 12;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_READ, ST_WRITE} chanState_t;
  typedef enum logic [1:0] {SEL_NODE, SEL_RD, SEL_WR} addrSel_t;

  typedef struct packed {
    logic             captWord;
    logic             captData;
    logic             stepBeat;
    logic             advNode;
    logic [IDX_W-1:0] wordIdx;
    addrSel_t         addrSel;
  } strobe_t;
endpackage

// File: rtl/lldma_ctrl.sv
module lldma_ctrl
  import lldma_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    swStart,
  input  logic    swCancel,
  input  logic    memReady,
  input  logic    lastBeat,
  input  logic    nextZero,
  output strobe_t strb,
  output logic    memReq,
  output logic    memWe,
  output logic    eventPulse,
  output logic    chanEn,
  output logic    listEn,
  output logic    busy
);
  chanState_t       state, nextState;
  logic [IDX_W-1:0] idx;
  logic             loadedSeen;
  logic             fetchDone, cmdDone;

  always_comb begin
    nextState    = state;
    strb         = '0;
    strb.wordIdx = idx;
    strb.addrSel = SEL_NODE;
    memReq       = 1'b0;
    memWe        = 1'b0;
    fetchDone    = 1'b0;
    cmdDone      = 1'b0;
    if (swCancel) begin
      nextState = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: if (swStart) nextState = ST_FETCH;
        ST_FETCH: begin
          memReq = 1'b1;
          if (memReady) begin
            strb.captWord = 1'b1;
            if (idx == IDX_W'(DESC_WORDS - 1)) begin
              fetchDone = 1'b1;
              nextState = ST_READ;
            end
          end
        end
        ST_READ: begin
          memReq       = 1'b1;
          strb.addrSel = SEL_RD;
          if (memReady) begin
            strb.captData = 1'b1;
            nextState     = ST_WRITE;
          end
        end
        ST_WRITE: begin
          memReq       = 1'b1;
          memWe        = 1'b1;
          strb.addrSel = SEL_WR;
          if (memReady) begin
            strb.stepBeat = 1'b1;
            if (lastBeat) begin
              cmdDone = 1'b1;
              if (nextZero) nextState = ST_IDLE;
              else begin
                strb.advNode = 1'b1;
                nextState    = ST_FETCH;
              end
            end else begin
              nextState = ST_READ;
            end
          end
        end
        default: nextState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      idx        <= '0;
      loadedSeen <= 1'b0;
      eventPulse <= 1'b0;
      chanEn     <= 1'b0;
      listEn     <= 1'b0;
    end else begin
      state      <= nextState;
      eventPulse <= (fetchDone && !loadedSeen) || cmdDone;
      if (swCancel || state != ST_FETCH) idx <= '0;
      else if (memReady)                 idx <= idx + 1'b1;
      if (fetchDone)             loadedSeen <= 1'b1;
      else if (state == ST_IDLE) loadedSeen <= 1'b0;
      if (swCancel || (cmdDone && nextZero)) begin
        chanEn <= 1'b0;
        listEn <= 1'b0;
      end else if (state == ST_IDLE && swStart) begin
        chanEn <= 1'b1;
        listEn <= 1'b1;
      end
    end
  end

  assign busy = (state != ST_IDLE);

  assert_event_gap_R5: assert property (@(posedge clk) disable iff (!rstN)
    eventPulse |=> !eventPulse);

  assert_cancel_stop_R8: assert property (@(posedge clk) disable iff (!rstN)
    swCancel |=> (state == ST_IDLE && !chanEn && !listEn && !eventPulse));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !memReq);

  assert_list_end_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(listEn) |-> (state == ST_IDLE));
endmodule

// File: rtl/lldma_dp.sv
module lldma_dp
  import lldma_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic              swNodeWr,
  input  logic [WORD_W-1:0] swNodeData,
  input  logic [WORD_W-1:0] memRdata,
  output logic [WORD_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  output logic              lastBeat,
  output logic              nextZero,
  output logic [WORD_W-1:0] genCfg,
  output logic [WORD_W-1:0] portCfg,
  output logic [WORD_W-1:0] srcAddr,
  output logic [WORD_W-1:0] dstAddr,
  output logic [SIZE_W-1:0] cmdSize,
  output logic [WORD_W-1:0] nodeAddr,
  output logic [SIZE_W-1:0] activeSize
);
  logic [WORD_W-1:0] nextNode;
  logic [WORD_W-1:0] holdWord;

  assign lastBeat = (activeSize < SIZE_W'(BEAT_BYTES));
  assign nextZero = (nextNode == '0);
  assign memWdata = holdWord;

  always_comb begin
    case (strb.addrSel)
      SEL_RD:  memAddr = srcAddr;
      SEL_WR:  memAddr = dstAddr;
      default: memAddr = nodeAddr + WORD_W'({strb.wordIdx, 2'b00});
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      genCfg     <= '0;
      portCfg    <= '0;
      srcAddr    <= '0;
      dstAddr    <= '0;
      cmdSize    <= '0;
      nextNode   <= '0;
      nodeAddr   <= '0;
      holdWord   <= '0;
      activeSize <= '1;
    end else begin
      if (swNodeWr)          nodeAddr <= swNodeData;
      else if (strb.advNode) nodeAddr <= nextNode;
      if (strb.captWord) begin
        case (strb.wordIdx)
          IDX_W'(0): genCfg  <= memRdata;
          IDX_W'(1): portCfg <= memRdata;
          IDX_W'(2): srcAddr <= memRdata;
          IDX_W'(3): dstAddr <= memRdata;
          IDX_W'(4): begin
            cmdSize    <= memRdata[SIZE_W-1:0];
            activeSize <= memRdata[SIZE_W-1:0];
          end
          IDX_W'(5): nextNode <= memRdata;
          default: ;
        endcase
      end
      if (strb.captData) holdWord <= memRdata;
      if (strb.stepBeat) begin
        if (genCfg[BIT_INC_RD]) srcAddr <= srcAddr + WORD_W'(BEAT_BYTES);
        if (genCfg[BIT_INC_WR]) dstAddr <= dstAddr + WORD_W'(BEAT_BYTES);
        activeSize <= lastBeat ? '1 : activeSize - SIZE_W'(BEAT_BYTES);
      end
    end
  end

  assert_fixed_src_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.stepBeat && !genCfg[BIT_INC_RD]) |=> $stable(srcAddr));
endmodule

// File: rtl/lldma_channel.sv
module lldma_channel
  import lldma_pkg::*;
#(
  parameter int REG_AW = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [WORD_W-1:0] regWdata,
  output logic [WORD_W-1:0] regRdata,
  output logic              memReq,
  output logic              memWe,
  output logic [WORD_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  input  logic              memReady,
  input  logic [WORD_W-1:0] memRdata,
  output logic              eventPulse
);
  strobe_t           strb;
  logic              swStart, swCancel, swNodeWr;
  logic              lastBeat, nextZero, chanEn, listEn, busy;
  logic [WORD_W-1:0] genCfg, portCfg, srcAddr, dstAddr, nodeAddr;
  logic [SIZE_W-1:0] cmdSize, activeSize;

  logic ctrlHit;
  assign ctrlHit  = regWe && (regAddr == REG_AW'(OFS_CTRL));
  assign swCancel = ctrlHit && regWdata[BIT_CANCEL];
  assign swStart  = ctrlHit && regWdata[BIT_LIST] && !regWdata[BIT_CANCEL];
  assign swNodeWr = regWe && (regAddr == REG_AW'(OFS_NODE)) && !busy;

  lldma_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .swStart(swStart), .swCancel(swCancel),
    .memReady(memReady), .lastBeat(lastBeat), .nextZero(nextZero),
    .strb(strb), .memReq(memReq), .memWe(memWe), .eventPulse(eventPulse),
    .chanEn(chanEn), .listEn(listEn), .busy(busy)
  );

  lldma_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .swNodeWr(swNodeWr),
    .swNodeData(regWdata), .memRdata(memRdata), .memAddr(memAddr),
    .memWdata(memWdata), .lastBeat(lastBeat), .nextZero(nextZero),
    .genCfg(genCfg), .portCfg(portCfg), .srcAddr(srcAddr), .dstAddr(dstAddr),
    .cmdSize(cmdSize), .nodeAddr(nodeAddr), .activeSize(activeSize)
  );

  always_comb begin
    regRdata = '0;
    case (regAddr)
      REG_AW'(OFS_GEN):    regRdata = genCfg;
      REG_AW'(OFS_PORT):   regRdata = portCfg;
      REG_AW'(OFS_SRC):    regRdata = srcAddr;
      REG_AW'(OFS_DST):    regRdata = dstAddr;
      REG_AW'(OFS_SIZE):   regRdata = WORD_W'(cmdSize);
      REG_AW'(OFS_NODE):   regRdata = nodeAddr;
      REG_AW'(OFS_CTRL): begin
        regRdata[BIT_EN]   = chanEn;
        regRdata[BIT_LIST] = listEn;
      end
      REG_AW'(OFS_ACTIVE): regRdata = WORD_W'(activeSize);
      default: regRdata = '0;
    endcase
  end

  assert_hold_req_R9: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady && !swCancel) |=>
      (memReq && $stable(memWe) && $stable(memAddr) && $stable(memWdata)));

  assert_node_lock_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && regWe && regAddr == REG_AW'(OFS_NODE) && !(memReq && memReady))
      |=> $stable(nodeAddr));
endmodule

// File: tb/sim_lldma_channel.sv
module sim_lldma_channel;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 5;
  // {src[7:0], dst[7:0], words[7:0], 5'b0, stall, rdInc, wrInc}
  localparam logic [31:0] VEC [NVEC] = '{
    32'h80_C0_01_03, 32'h84_C8_04_07, 32'h90_D0_03_06,
    32'hA0_E0_03_01, 32'h80_F0_04_07
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        memReq, memWe, memReady, eventPulse;
  logic [31:0] memAddr, memWdata, memRdata;
  logic        stall = 1'b0;
  logic [1:0]  cyc = '0;
  logic [31:0] mem [64];
  logic [31:0] shadow [64];
  int          evtCount = 0;
  int          nChecks = 0;
  int          nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lldma_channel u0 (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .memReq(memReq),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memReady(memReady), .memRdata(memRdata), .eventPulse(eventPulse)
  );

  assign memReady = !stall || (cyc != 2'd3);
  assign memRdata = mem[memAddr[7:2]];

  always @(posedge clk) begin
    cyc <= cyc + 2'd1;
    if (eventPulse) evtCount <= evtCount + 1;
    if (memReq && memWe && memReady) mem[memAddr[7:2]] <= memWdata;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic regRead(input logic [7:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic putDesc(input int base, input logic [31:0] gen, input logic [31:0] src,
                         input logic [31:0] dst, input logic [31:0] size, input logic [31:0] nxt);
    mem[base/4 + 0] = gen;
    mem[base/4 + 1] = 32'h0;
    mem[base/4 + 2] = src;
    mem[base/4 + 3] = dst;
    mem[base/4 + 4] = size;
    mem[base/4 + 5] = nxt;
    mem[base/4 + 6] = 32'h0;
    mem[base/4 + 7] = 32'h11;
  endtask

  task automatic model(input int src, input int dst, input int nw, input bit ri, input bit wi);
    for (int b = 0; b < nw; b++)
      shadow[(dst + (wi ? 4*b : 0)) / 4] = shadow[(src + (ri ? 4*b : 0)) / 4];
  endtask

  task automatic snap();
    for (int i = 0; i < 64; i++) shadow[i] = mem[i];
  endtask

  task automatic compareMem(input string tag);
    logic [31:0] bad;
    int          where;
    bad = 0; where = -1;
    for (int i = 0; i < 64; i++)
      if (mem[i] !== shadow[i] && where < 0) begin where = i; bad = mem[i]; end
    if (where < 0) check(tag, 32'h0, 32'h0);
    else check($sformatf("%s word %0d", tag, where), bad, shadow[where]);
  endtask

  task automatic waitIdle(input string tag);
    logic [31:0] v;
    int          n;
    n = 0;
    @(negedge clk);
    regRead(8'h1C, v);
    while (v[4] && n < 5000) begin
      @(negedge clk);
      regRead(8'h1C, v);
      n++;
    end
    if (n >= 5000) check({tag, " timeout"}, v, 32'h0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL R5 watchdog expired actual=hung expected=done");
    summary();
  end

  initial begin
    logic [31:0] v;
    int          e0;
    for (int i = 0; i < 64; i++) mem[i] = 32'hA5000000 + i;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 memReq at reset", {31'b0, memReq}, 32'h0);
    regRead(8'h1C, v); check("R11 ctrl at reset", v, 32'h0);
    regRead(8'h30, v); check("R4 active size at reset", v, 32'h00FFFFFF);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check("R11 no event after reset", evtCount, 0);
    check("R11 memReq idle", {31'b0, memReq}, 32'h0);

    // table-driven single-command lists
    for (int k = 0; k < NVEC; k++) begin
      int src, dst, nw;
      bit ri, wi;
      logic [31:0] gen;
      src = int'(VEC[k][31:24]); dst = int'(VEC[k][23:16]); nw = int'(VEC[k][15:8]);
      ri = VEC[k][1]; wi = VEC[k][0];
      gen = 32'h22 | (32'(ri) << 8) | (32'(wi) << 12);
      putDesc('h40, gen, src, dst, nw*4 - 1, 0);
      snap();
      model(src, dst, nw, ri, wi);
      stall = VEC[k][2];
      e0 = evtCount;
      regWrite(8'h14, 32'h40);
      regWrite(8'h1C, 32'h11);
      waitIdle("R1 vector");
      check($sformatf("R5 events vec %0d", k), evtCount - e0, 2);
      compareMem($sformatf("R3 data vec %0d", k));
      regRead(8'h1C, v); check($sformatf("R6 ctrl cleared vec %0d", k), v, 32'h0);
      regRead(8'h30, v); check($sformatf("R4 active size vec %0d", k), v, 32'h00FFFFFF);
      regRead(8'h08, v); check($sformatf("R2 final src vec %0d", k), v, src + (ri ? 4*nw : 0));
    end
    stall = 1'b0;

    // R6 chained two nodes
    putDesc('h40, 32'h1122, 'h88, 'hC0, 7, 'h60);
    putDesc('h60, 32'h1122, 'hA8, 'hD8, 11, 0);
    snap(); model('h88, 'hC0, 2, 1, 1); model('hA8, 'hD8, 3, 1, 1);
    e0 = evtCount;
    regWrite(8'h14, 32'h40);
    regWrite(8'h1C, 32'h11);
    waitIdle("R6 chain");
    check("R6 chain events", evtCount - e0, 3);
    compareMem("R6 chain data");
    regRead(8'h14, v); check("R6 node follows pointer", v, 32'h60);

    // R10 node write while busy ignored; R1 status while running
    stall = 1'b1;
    putDesc('h40, 32'h1122, 'h80, 'hE0, 15, 0);
    e0 = evtCount;
    regWrite(8'h14, 32'h40);
    regWrite(8'h1C, 32'h11);
    regRead(8'h1C, v); check("R1 ctrl while running", v, 32'h11);
    regWrite(8'h14, 32'h60);
    waitIdle("R10 run");
    regRead(8'h14, v); check("R10 node write ignored", v, 32'h40);
    check("R10 no extra node run", evtCount - e0, 2);
    stall = 1'b0;

    // R7 cyclic ring, R8 cancel
    putDesc('h40, 32'h1122, 'h80, 'hC0, 3, 'h60);
    putDesc('h60, 32'h1122, 'h84, 'hC4, 3, 'h40);
    e0 = evtCount;
    regWrite(8'h14, 32'h40);
    regWrite(8'h1C, 32'h11);
    repeat (300) @(negedge clk);
    regRead(8'h1C, v); check("R7 ring still running", v, 32'h11);
    check("R7 ring events keep coming", 32'(evtCount - e0 >= 5), 32'h1);
    regWrite(8'h1C, 32'h00100000);
    check("R8 no request after cancel", {31'b0, memReq}, 32'h0);
    regRead(8'h1C, v); check("R8 ctrl after cancel", v, 32'h0);
    e0 = evtCount;
    repeat (30) @(negedge clk);
    check("R8 events stopped", evtCount - e0, 0);
    check("R8 still quiet", {31'b0, memReq}, 32'h0);

    summary();
  end
endmodule